// File: doc/BRIEF.md
# Flash Write-Protection and Autoselect Front End

This block is the synchronous front end of the command interface of a parallel flash array. It sits between the external strobes and the command decoder. The strobes are active-low chip-enables (one per byte lane), one write-enable and one output-enable. The block decides when a real write cycle has happened and hands the decoder one command word per accepted cycle. That word carries the address, the data, the lanes that were selected and an operation class. An external unlock decoder supplies the operation class on `op_sel`.

Every strobe pin first passes a minimum-pulse filter. A write is then accepted only when all of the following hold:
- the pins are in the write state for the whole low phase of write-enable;
- the supply is good;
- the strobe was not already asserted when power came up;
- for a program or erase, the target sector is not protected.

The same filtered pins drive an identification readout that is placed on each selected byte lane. The array itself, high-voltage detection, the full unlock sequence and the program/erase timing live elsewhere.

Accepted commands leave on a valid/ready stream. `cmd_valid` stays high and the payload stays frozen until `cmd_ready` is seen high at a clock edge. A qualified write that completes while a command is still held is discarded. The held command is not replaced. Pins are assumed to be already synchronous to `clk`. Address, data and `op_sel` must stay stable for MIN_PULSE+1 cycles after write-enable rises, because they are captured when the filtered rising edge is detected.

Top module: `flash_cmd_frontend`

## Requirements
- R1: A command is produced only for a write-enable low phase that ends in a rising edge, during which at least one chip-enable lane was low and output-enable was high. `cmd_addr` and `cmd_data` carry `addr` and `wdata` from the capture cycle. `cmd_lanes` bit i is 1 when `ce_n[i]` was low. `cmd_op` carries `op_sel`.
- R2: If output-enable is low, or no chip-enable lane is low, in any cycle of the filtered write-enable low phase, no command is produced.
- R3: A level on any strobe pin lasting fewer than MIN_PULSE clock cycles is ignored. A level lasting MIN_PULSE cycles or more is taken.
- R4: While `pwr_good` is low, no command is produced, a held command is dropped, `prot_reject` is cleared and the autoselect outputs are zero.
- R5: If write-enable is already low when `pwr_good` rises, the following rising edge is not taken as a command. The inhibit ends once write-enable is seen high, and the next complete low/high pair is accepted.
- R6: A program (`op_sel`=01) or erase (`op_sel`=10 or 11) aimed at a protected sector produces no command and sets `prot_reject`. The sector is `addr[AW-1 -: SW]`. `prot_reject` stays set until reset or lockout. A plain write (`op_sel`=00) to a protected sector is still passed on.
- R7: After reset every sector is unprotected. A cycle with `prot_set` high protects sector `prot_sector`, and a cycle with `prot_clr` high unprotects it. `prot_set` wins if both are high. Unprotecting re-enables both program and erase.
- R8: With `autosel` high, output-enable low and chip-enable lane i low, `rd_oe[i]`=1 and byte lane i of `rd_data` carries a code. The code is 20h when `addr[0]`=1. When `addr[0]`=0 and `addr[1]`=1, it is 01h if the addressed sector is protected and 00h if not. Otherwise it is 01h.
- R9: A lane whose chip-enable is high, or any lane while output-enable is high or `autosel` is low, has `rd_oe` bit 0 and an all-zero data byte.
- R10: While `cmd_valid` is high and `cmd_ready` is low, the command payload is held unchanged, and a newly qualified write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply above lockout threshold |
| ce_n | input | LANES | Active-low chip-enable, one per byte lane |
| we_n | input | 1 | Active-low write-enable |
| oe_n | input | 1 | Active-low output-enable |
| addr | input | AW | Address bus |
| wdata | input | 8*LANES | Write data bus |
| op_sel | input | 2 | Operation class from the unlock decoder (00 write, 01 program, 1x erase) |
| autosel | input | 1 | Identification readout mode |
| prot_set | input | 1 | Protect the sector on `prot_sector` |
| prot_clr | input | 1 | Unprotect the sector on `prot_sector` |
| prot_sector | input | SW | Sector index for protect/unprotect |
| cmd_valid | output | 1 | Command word available |
| cmd_ready | input | 1 | Consumer accepts the command word |
| cmd_addr | output | AW | Captured address |
| cmd_data | output | 8*LANES | Captured data |
| cmd_lanes | output | LANES | Lanes selected during the write |
| cmd_op | output | 2 | Captured operation class |
| prot_reject | output | 1 | Sticky: program/erase hit a protected sector |
| rd_oe | output | LANES | Per-lane readout enable |
| rd_data | output | 8*LANES | Identification readout bytes |

## Verification
Two functions can act on the output stage in the same cycle. The first is back-pressure holding a command. The second is either a newly qualified write or the supply lockout. Both are provoked by keeping `cmd_ready` low while a second full write completes, and separately while `pwr_good` drops. The scoreboard then confirms two things: the first payload is the only one ever delivered in the first case, and nothing is delivered at all in the second. Protection rejection and the power-up inhibit are judged the same way, by an unchanged transfer count together with the state of the sticky flag.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_PROG  = 2'b01,
    OP_ERASE = 2'b10
  } op_e;

  localparam logic [7:0] ID_MAKER   = 8'h01;
  localparam logic [7:0] ID_DEVICE  = 8'h20;
  localparam logic [7:0] ID_LOCKED  = 8'h01;
  localparam logic [7:0] ID_OPEN    = 8'h00;

  // Any class other than a plain write alters the array and is subject to protection.
  function automatic logic alters_array(input logic [1:0] op);
    return op != OP_WRITE;
  endfunction

  function automatic logic [7:0] id_code(input logic a0, input logic a1, input logic locked);
    if (a0)      return ID_DEVICE;
    else if (a1) return locked ? ID_LOCKED : ID_OPEN;
    else         return ID_MAKER;
  endfunction

endpackage

// File: rtl/flash_fe_glitch_filter.sv
module flash_fe_glitch_filter #(
  parameter int   MIN_PULSE = 4,
  parameter logic RST_VAL   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic din,
  output logic dout
);

  generate
    if (MIN_PULSE <= 1) begin : g_pass
      logic unused_clr;
      assign unused_clr = clr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dout <= RST_VAL;
        else        dout <= din;
      end
    end else begin : g_count
      localparam int CW = $clog2(MIN_PULSE);
      localparam logic [CW-1:0] LAST = CW'(MIN_PULSE - 1);
      logic [CW-1:0] run;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dout <= RST_VAL;
          run  <= '0;
        end else if (clr) begin
          // during lockout the filter tracks the pin so a held level is seen as held
          dout <= din;
          run  <= '0;
        end else if (din == dout) begin
          run <= '0;
        end else if (run == LAST) begin
          dout <= din;
          run  <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/flash_fe_strobe_qual.sv
module flash_fe_strobe_qual #(
  parameter int LANES = 4,
  parameter int AW    = 17,
  parameter int DW    = 8 * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock,
  input  logic [LANES-1:0] ce_f,
  input  logic             we_f,
  input  logic             oe_f,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    data,
  input  logic [1:0]       op,
  output logic             acc,
  output logic [AW-1:0]    acc_addr,
  output logic [DW-1:0]    acc_data,
  output logic [LANES-1:0] acc_lanes,
  output logic [1:0]       acc_op
);

  logic             we_q;
  logic             armed;
  logic             spoiled;
  logic [LANES-1:0] lanes_seen;

  logic any_sel, inhibit, we_rise;
  assign any_sel = |(~ce_f);
  assign inhibit = ~any_sel | ~oe_f;
  assign we_rise = we_f & ~we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q       <= 1'b1;
      armed      <= 1'b0;
      spoiled    <= 1'b0;
      lanes_seen <= '0;
      acc        <= 1'b0;
      acc_addr   <= '0;
      acc_data   <= '0;
      acc_lanes  <= '0;
      acc_op     <= '0;
    end else if (lock) begin
      we_q    <= we_f;
      armed   <= 1'b0;
      spoiled <= 1'b0;
      acc     <= 1'b0;
    end else begin
      we_q <= we_f;
      acc  <= 1'b0;
      if (we_f) begin
        // a high level on write-enable ends the power-up inhibit
        armed   <= 1'b1;
        spoiled <= 1'b0;
      end else begin
        spoiled    <= spoiled | inhibit;
        lanes_seen <= ~ce_f;
      end
      if (we_rise && armed && !spoiled) begin
        acc       <= 1'b1;
        acc_addr  <= addr;
        acc_data  <= data;
        acc_lanes <= lanes_seen;
        acc_op    <= op;
      end
    end
  end

endmodule

// File: rtl/flash_fe_sector_guard.sv
module flash_fe_sector_guard #(
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prot_set,
  input  logic          prot_clr,
  input  logic [SW-1:0] prot_sel,
  input  logic [SW-1:0] chk_sel,
  input  logic [SW-1:0] rd_sel,
  output logic          chk_locked,
  output logic          rd_locked
);

  localparam int SECTORS = 1 << SW;

  logic [SECTORS-1:0] locked;

  generate
    for (genvar s = 0; s < SECTORS; s++) begin : g_sector
      logic hit;
      assign hit = (prot_sel == SW'(s));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                locked[s] <= 1'b0;
        else if (prot_set && hit)  locked[s] <= 1'b1;
        else if (prot_clr && hit)  locked[s] <= 1'b0;
      end
    end
  endgenerate

  assign chk_locked = locked[chk_sel];
  assign rd_locked  = locked[rd_sel];

endmodule

// File: rtl/flash_fe_autosel_rd.sv
module flash_fe_autosel_rd
  import flash_fe_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lock,
  input  logic               autosel,
  input  logic               oe_f,
  input  logic [LANES-1:0]   ce_f,
  input  logic               a0,
  input  logic               a1,
  input  logic               sec_locked,
  output logic [LANES-1:0]   rd_oe,
  output logic [8*LANES-1:0] rd_data
);

  logic [7:0] code;
  assign code = id_code(a0, a1, sec_locked);

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic       drive;
      logic       lane_oe;
      logic [7:0] lane_byte;
      assign drive = autosel & ~oe_f & ~ce_f[l];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lane_oe   <= 1'b0;
          lane_byte <= '0;
        end else if (lock) begin
          lane_oe   <= 1'b0;
          lane_byte <= '0;
        end else begin
          lane_oe   <= drive;
          lane_byte <= drive ? code : 8'h00;
        end
      end
      assign rd_oe[l]         = lane_oe;
      assign rd_data[8*l +: 8] = lane_byte;
    end
  endgenerate

endmodule

// File: rtl/flash_cmd_frontend.sv
module flash_cmd_frontend
  import flash_fe_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int AW        = 17,
  parameter int SW        = 3,
  parameter int MIN_PULSE = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_good,
  input  logic [LANES-1:0]   ce_n,
  input  logic               we_n,
  input  logic               oe_n,
  input  logic [AW-1:0]      addr,
  input  logic [8*LANES-1:0] wdata,
  input  logic [1:0]         op_sel,
  input  logic               autosel,
  input  logic               prot_set,
  input  logic               prot_clr,
  input  logic [SW-1:0]      prot_sector,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [AW-1:0]      cmd_addr,
  output logic [8*LANES-1:0] cmd_data,
  output logic [LANES-1:0]   cmd_lanes,
  output logic [1:0]         cmd_op,
  output logic               prot_reject,
  output logic [LANES-1:0]   rd_oe,
  output logic [8*LANES-1:0] rd_data
);

  localparam int DW = 8 * LANES;

  logic lock;
  assign lock = ~pwr_good;

  // strobe filters: one per chip-enable lane plus write- and output-enable
  logic [LANES-1:0] ce_f;
  logic             we_f, oe_f;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_ce_filt
      flash_fe_glitch_filter #(.MIN_PULSE(MIN_PULSE), .RST_VAL(1'b1)) u_filt (
        .clk(clk), .rst_n(rst_n), .clr(lock), .din(ce_n[l]), .dout(ce_f[l])
      );
    end
  endgenerate

  flash_fe_glitch_filter #(.MIN_PULSE(MIN_PULSE), .RST_VAL(1'b1)) u_we_filt (
    .clk(clk), .rst_n(rst_n), .clr(lock), .din(we_n), .dout(we_f)
  );

  flash_fe_glitch_filter #(.MIN_PULSE(MIN_PULSE), .RST_VAL(1'b1)) u_oe_filt (
    .clk(clk), .rst_n(rst_n), .clr(lock), .din(oe_n), .dout(oe_f)
  );

  logic             acc;
  logic [AW-1:0]    acc_addr;
  logic [DW-1:0]    acc_data;
  logic [LANES-1:0] acc_lanes;
  logic [1:0]       acc_op;

  flash_fe_strobe_qual #(.LANES(LANES), .AW(AW), .DW(DW)) u_qual (
    .clk(clk), .rst_n(rst_n), .lock(lock),
    .ce_f(ce_f), .we_f(we_f), .oe_f(oe_f),
    .addr(addr), .data(wdata), .op(op_sel),
    .acc(acc), .acc_addr(acc_addr), .acc_data(acc_data),
    .acc_lanes(acc_lanes), .acc_op(acc_op)
  );

  logic chk_locked, rd_locked;

  flash_fe_sector_guard #(.SW(SW)) u_guard (
    .clk(clk), .rst_n(rst_n),
    .prot_set(prot_set), .prot_clr(prot_clr), .prot_sel(prot_sector),
    .chk_sel(acc_addr[AW-1 -: SW]), .rd_sel(addr[AW-1 -: SW]),
    .chk_locked(chk_locked), .rd_locked(rd_locked)
  );

  flash_fe_autosel_rd #(.LANES(LANES)) u_idrd (
    .clk(clk), .rst_n(rst_n), .lock(lock),
    .autosel(autosel), .oe_f(oe_f), .ce_f(ce_f),
    .a0(addr[0]), .a1(addr[1]), .sec_locked(rd_locked),
    .rd_oe(rd_oe), .rd_data(rd_data)
  );

  // output stage: one held command word, sticky rejection flag
  logic blocked, slot_free;
  assign blocked   = acc & alters_array(acc_op) & chk_locked;
  assign slot_free = ~cmd_valid | cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid   <= 1'b0;
      cmd_addr    <= '0;
      cmd_data    <= '0;
      cmd_lanes   <= '0;
      cmd_op      <= '0;
      prot_reject <= 1'b0;
    end else if (lock) begin
      cmd_valid   <= 1'b0;
      prot_reject <= 1'b0;
    end else begin
      if (cmd_valid && cmd_ready) cmd_valid <= 1'b0;
      if (acc && !blocked && slot_free) begin
        cmd_valid <= 1'b1;
        cmd_addr  <= acc_addr;
        cmd_data  <= acc_data;
        cmd_lanes <= acc_lanes;
        cmd_op    <= acc_op;
      end
      if (blocked) prot_reject <= 1'b1;
    end
  end

endmodule

// File: rtl/flash_fe_checker.sv
module flash_fe_checker #(
  parameter int LANES = 4,
  parameter int AW    = 17
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pwr_good,
  input logic               autosel,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [AW-1:0]      cmd_addr,
  input logic [8*LANES-1:0] cmd_data,
  input logic [LANES-1:0]   cmd_lanes,
  input logic               prot_reject,
  input logic [LANES-1:0]   rd_oe,
  input logic [8*LANES-1:0] rd_data
);

  // R1
  lanes_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_lanes != '0);

  // R4
  lockout_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> !cmd_valid && !prot_reject && rd_oe == '0);

  // R4
  new_cmd_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> $past(pwr_good));

  // R6
  reject_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_reject && pwr_good |=> prot_reject);

  // R10
  hold_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready && pwr_good |=>
      cmd_valid && $stable(cmd_addr) && $stable(cmd_data) && $stable(cmd_lanes));

  // R9
  readout_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_oe != '0) |-> $past(autosel) && $past(pwr_good));

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      // R9
      lane_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_oe[l] |-> rd_data[8*l +: 8] == 8'h00);
    end
  endgenerate

endmodule

bind flash_cmd_frontend flash_fe_checker #(.LANES(LANES), .AW(AW)) u_fe_chk (
  .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .autosel(autosel),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
  .cmd_data(cmd_data), .cmd_lanes(cmd_lanes), .prot_reject(prot_reject),
  .rd_oe(rd_oe), .rd_data(rd_data)
);

// File: tb/flash_cmd_frontend_test.sv
module flash_cmd_frontend_test;

  localparam int LANES = 4;
  localparam int AW    = 17;
  localparam int SW    = 3;
  localparam int MINP  = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pwr_good = 1'b0;
  logic [LANES-1:0] ce_n = '1;
  logic             we_n = 1'b1;
  logic             oe_n = 1'b1;
  logic [AW-1:0]    addr = '0;
  logic [31:0]      wdata = '0;
  logic [1:0]       op_sel = 2'b00;
  logic             autosel = 1'b0;
  logic             prot_set = 1'b0;
  logic             prot_clr = 1'b0;
  logic [SW-1:0]    prot_sector = '0;
  logic             cmd_valid;
  logic             cmd_ready = 1'b1;
  logic [AW-1:0]    cmd_addr;
  logic [31:0]      cmd_data;
  logic [LANES-1:0] cmd_lanes;
  logic [1:0]       cmd_op;
  logic             prot_reject;
  logic [LANES-1:0] rd_oe;
  logic [31:0]      rd_data;

  flash_cmd_frontend #(.LANES(LANES), .AW(AW), .SW(SW), .MIN_PULSE(MINP)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .wdata(wdata), .op_sel(op_sel), .autosel(autosel),
    .prot_set(prot_set), .prot_clr(prot_clr), .prot_sector(prot_sector),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_lanes(cmd_lanes), .cmd_op(cmd_op),
    .prot_reject(prot_reject), .rd_oe(rd_oe), .rd_data(rd_data)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [AW-1:0]    a;
    logic [31:0]      d;
    logic [LANES-1:0] l;
    logic [1:0]       o;
    string            req;
  } exp_t;

  exp_t  sb[$];
  int    checks = 0;
  int    errors = 0;
  int    xfers  = 0;
  bit    done   = 1'b0;
  string cur_req = "R1";

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_cmd(input logic [AW-1:0] a, input logic [31:0] d,
                            input logic [LANES-1:0] lanes, input logic [1:0] o,
                            input string req);
    exp_t e;
    e.a = a; e.d = d; e.l = lanes; e.o = o; e.req = req;
    sb.push_back(e);
  endtask

  // driver: one full write cycle; optionally registers the expected command
  task automatic wr(input logic [LANES-1:0] lanes_n, input logic [AW-1:0] a,
                    input logic [31:0] d, input logic [1:0] o, input int low,
                    input bit expect_it, input string req);
    if (expect_it) expect_cmd(a, d, ~lanes_n, o, req);
    ce_n = lanes_n; addr = a; wdata = d; op_sel = o;
    tick(1);
    we_n = 1'b0;
    tick(low);
    we_n = 1'b1;
    tick(MINP + 4);
    ce_n = '1;
    tick(2);
  endtask

  // monitor: compares every transfer against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && cmd_valid && cmd_ready) begin
        xfers++;
        if (sb.size() == 0) begin
          check(1'b0, cur_req, "unexpected command addr", 64'(cmd_addr), 64'h0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(cmd_addr == e.a,  e.req, "cmd_addr",  64'(cmd_addr),  64'(e.a));
          check(cmd_data == e.d,  e.req, "cmd_data",  64'(cmd_data),  64'(e.d));
          check(cmd_lanes == e.l, e.req, "cmd_lanes", 64'(cmd_lanes), 64'(e.l));
          check(cmd_op == e.o,    e.req, "cmd_op",    64'(cmd_op),    64'(e.o));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int snap;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // reset state
    check(cmd_valid == 1'b0, "R4", "cmd_valid after reset", 64'(cmd_valid), 64'h0);
    check(prot_reject == 1'b0, "R6", "prot_reject after reset", 64'(prot_reject), 64'h0);
    check(rd_oe == '0, "R9", "rd_oe after reset", 64'(rd_oe), 64'h0);
    pwr_good = 1'b1;
    tick(4);

    // R1: basic writes over different lane patterns and op classes
    cur_req = "R1";
    wr(4'b1110, 17'h00123, 32'hA5A5_0001, 2'b00, 6, 1'b1, "R1");
    wr(4'b0000, 17'h1FFFC, 32'h1234_5678, 2'b01, 6, 1'b1, "R1");
    wr(4'b1010, 17'h0BEEF, 32'hDEAD_BEEF, 2'b10, 8, 1'b1, "R1");

    // R2: output-enable low through the low phase blocks the write
    cur_req = "R2";
    snap = xfers;
    oe_n = 1'b0;
    wr(4'b1110, 17'h00044, 32'h0000_0044, 2'b00, 6, 1'b0, "R2");
    oe_n = 1'b1;
    tick(2);
    check(xfers == snap, "R2", "transfers with oe low", 64'(xfers), 64'(snap));

    // R3: short write-enable pulse ignored, exact minimum accepted
    cur_req = "R3";
    snap = xfers;
    wr(4'b1110, 17'h00055, 32'h0000_0055, 2'b00, MINP - 1, 1'b0, "R3");
    check(xfers == snap, "R3", "transfers after short pulse", 64'(xfers), 64'(snap));
    wr(4'b1101, 17'h00066, 32'h0000_0066, 2'b00, MINP, 1'b1, "R3");

    // R3: short glitch on output-enable during the low phase is ignored
    expect_cmd(17'h00077, 32'h0000_0077, 4'b0011, 2'b00, "R3");
    ce_n = 4'b1100; addr = 17'h00077; wdata = 32'h0000_0077; op_sel = 2'b00;
    tick(1);
    we_n = 1'b0;
    tick(2);
    oe_n = 1'b0;
    tick(MINP - 1);
    oe_n = 1'b1;
    tick(4);
    we_n = 1'b1;
    tick(MINP + 4);
    ce_n = '1;
    tick(2);

    // R3: short glitch on chip-enable during the low phase is ignored
    expect_cmd(17'h00088, 32'h0000_0088, 4'b0011, 2'b00, "R3");
    ce_n = 4'b1100; addr = 17'h00088; wdata = 32'h0000_0088;
    tick(1);
    we_n = 1'b0;
    tick(2);
    ce_n = 4'b1111;
    tick(MINP - 1);
    ce_n = 4'b1100;
    tick(4);
    we_n = 1'b1;
    tick(MINP + 4);
    ce_n = '1;
    tick(2);

    // R10: back-pressure holds the first command, the second is dropped
    cur_req = "R10";
    cmd_ready = 1'b0;
    wr(4'b1110, 17'h00A0A, 32'hAAAA_0001, 2'b00, 6, 1'b1, "R10");
    wr(4'b1110, 17'h00B0B, 32'hBBBB_0002, 2'b00, 6, 1'b0, "R10");
    tick(3);
    check(cmd_valid == 1'b1, "R10", "cmd_valid held", 64'(cmd_valid), 64'h1);
    check(cmd_data == 32'hAAAA_0001, "R10", "held cmd_data", 64'(cmd_data), 64'hAAAA0001);
    cmd_ready = 1'b1;
    tick(4);

    // R6/R7: protection of sector 5
    cur_req = "R6";
    prot_sector = 3'd5; prot_set = 1'b1;
    tick(1);
    prot_set = 1'b0;
    snap = xfers;
    wr(4'b1110, 17'h14010, 32'h0000_0100, 2'b01, 6, 1'b0, "R6");
    check(prot_reject == 1'b1, "R6", "reject after program to protected", 64'(prot_reject), 64'h1);
    check(xfers == snap, "R6", "transfers after blocked program", 64'(xfers), 64'(snap));
    wr(4'b1110, 17'h14020, 32'h0000_0200, 2'b11, 6, 1'b0, "R6");
    check(xfers == snap, "R6", "transfers after blocked erase", 64'(xfers), 64'(snap));
    wr(4'b1110, 17'h14030, 32'h0000_0300, 2'b00, 6, 1'b1, "R6");
    wr(4'b1110, 17'h08010, 32'h0000_0400, 2'b01, 6, 1'b1, "R6");
    cur_req = "R7";
    prot_clr = 1'b1;
    tick(1);
    prot_clr = 1'b0;
    wr(4'b1110, 17'h14040, 32'h0000_0500, 2'b01, 6, 1'b1, "R7");
    wr(4'b1110, 17'h14050, 32'h0000_0600, 2'b10, 6, 1'b1, "R7");
    check(prot_reject == 1'b1, "R6", "reject stays set", 64'(prot_reject), 64'h1);

    // R8: identification codes on lanes 1 and 3
    prot_set = 1'b1;
    tick(1);
    prot_set = 1'b0;
    autosel = 1'b1; ce_n = 4'b0101; oe_n = 1'b0; addr = 17'h00000;
    tick(MINP + 4);
    check(rd_oe == 4'b1010, "R8", "rd_oe", 64'(rd_oe), 64'hA);
    check(rd_data == 32'h0100_0100, "R8", "maker code", 64'(rd_data), 64'h01000100);
    addr = 17'h00001;
    tick(3);
    check(rd_data == 32'h2000_2000, "R8", "device code", 64'(rd_data), 64'h20002000);
    addr = 17'h14002;
    tick(3);
    check(rd_data == 32'h0100_0100, "R8", "protected sector", 64'(rd_data), 64'h01000100);
    addr = 17'h08002;
    tick(3);
    check(rd_data == 32'h0000_0000, "R8", "open sector", 64'(rd_data), 64'h0);
    addr = 17'h14003;
    tick(3);
    check(rd_data == 32'h2000_2000, "R8", "a0 priority", 64'(rd_data), 64'h20002000);

    // R9: readout silent with oe high, or outside autoselect
    oe_n = 1'b1;
    tick(MINP + 4);
    check(rd_oe == '0 && rd_data == '0, "R9", "readout with oe high",
          64'(rd_data), 64'h0);
    oe_n = 1'b0; autosel = 1'b0;
    tick(MINP + 4);
    check(rd_oe == '0 && rd_data == '0, "R9", "readout outside autoselect",
          64'(rd_oe), 64'h0);
    oe_n = 1'b1; ce_n = '1;
    tick(MINP + 4);

    // R4: lockout drops a held command and clears the reject flag
    cur_req = "R4";
    cmd_ready = 1'b0;
    wr(4'b1110, 17'h00C0C, 32'hCCCC_0003, 2'b00, 6, 1'b0, "R4");
    check(cmd_valid == 1'b1, "R4", "command pending before lockout", 64'(cmd_valid), 64'h1);
    pwr_good = 1'b0;
    tick(2);
    check(cmd_valid == 1'b0, "R4", "cmd_valid in lockout", 64'(cmd_valid), 64'h0);
    check(prot_reject == 1'b0, "R4", "reject in lockout", 64'(prot_reject), 64'h0);
    cmd_ready = 1'b1;
    snap = xfers;
    wr(4'b1110, 17'h00D0D, 32'hDDDD_0004, 2'b00, 6, 1'b0, "R4");
    pwr_good = 1'b1;
    tick(6);
    check(xfers == snap, "R4", "transfers across lockout", 64'(xfers), 64'(snap));

    // R5: strobe already low at power-up is not a command
    cur_req = "R5";
    pwr_good = 1'b0;
    ce_n = 4'b1110; we_n = 1'b0; oe_n = 1'b1;
    addr = 17'h00E0E; wdata = 32'hEEEE_0005; op_sel = 2'b00;
    tick(6);
    pwr_good = 1'b1;
    tick(8);
    we_n = 1'b1;
    tick(MINP + 6);
    check(xfers == snap, "R5", "transfers after power-up edge", 64'(xfers), 64'(snap));
    expect_cmd(17'h00E0E, 32'hEEEE_0005, 4'b0001, 2'b00, "R5");
    we_n = 1'b0;
    tick(6);
    we_n = 1'b1;
    tick(MINP + 4);
    ce_n = '1;
    tick(10);

    check(sb.size() == 0, "R1", "commands left undelivered", 64'(sb.size()), 64'h0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule